// File: doc/BRIEF.md
# Echoed-Clock Serial Converter Capture Controller

This block runs the host side of a 16-bit successive-approximation converter whose serial output is read back with an echoed clock. It starts a conversion with a short, bounded pulse, waits a fixed number of system cycles for the most significant bit to be ready, and then drives a burst of exactly sixteen clock pulses. The converter sends the clock back as an echo together with the data. The block shifts the data in on rising edges of that echo, most significant bit first. It then moves the finished word into the system clock domain through a toggle handshake and presents it with a one-cycle valid strobe.

A conversion starts on a one-cycle request or, in free-running mode, every fixed number of cycles. Requests that arrive while a conversion is still in progress have no effect. The first result after each reset is dropped, because the converter's first conversion after power-up is not valid. Pulse width, wait time, clock divider and cycle period are parameters. An elaboration-time flag reports a timing setup in which the burst cannot finish inside one cycle period.

Top module: `adc_echo_capture`

## Requirements
- R1: While rst_n is low, cnv_o, sclk_o and word_vld_o are 0. After reset the first-result drop is armed again.
- R2: A start_req sampled high on a clock edge while idle makes cnv_o high from that edge for exactly CNV_HI cycles.
- R3: A start_req that arrives while a conversion is in progress (from the cycle cnv_o rises until the burst ends) starts no extra conversion.
- R4: sclk_o is low except during the burst. The burst begins MSB_WAIT cycles after cnv_o rises and has exactly 16 pulses, each DIV cycles high followed by DIV cycles low. sclk_o is never high in the same cycle as cnv_o.
- R5: With free_run high, conversions start every CYC_CNT cycles. If the block has been idle for at least CYC_CNT-1 cycles, one starts at once.
- R6: The bit sampled on the k-th echo_clk rising edge of a burst (k = 1..16) becomes bit 16-k of word_o, so the first bit is bit 15.
- R7: word_vld_o is high for one cycle, on the third system clock edge after the 16th echo_clk rising edge. In that same cycle word_o holds the captured word, and it holds that value until the next valid word.
- R8: The first completed word after reset gives no word_vld_o pulse.
- R9: cfg_err_o is 1 exactly when MSB_WAIT + 2*16*DIV >= CYC_CNT, MSB_WAIT <= CNV_HI, CNV_HI < 1 or DIV < 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-cycle conversion request |
| free_run | input | 1 | Enables periodic conversions every CYC_CNT cycles |
| echo_clk | input | 1 | Clock echoed back by the converter |
| echo_dat | input | 1 | Serial data, changes on echo_clk falling edges |
| cnv_o | output | 1 | Conversion-start pulse |
| sclk_o | output | 1 | Burst clock driven to the converter, idles low |
| word_o | output | 16 | Last captured conversion word |
| word_vld_o | output | 1 | One-cycle strobe for a new word |
| cfg_err_o | output | 1 | Timing parameters do not fit the cycle period |

## Verification
The case that is hardest to reach from the ports is a reset asserted in the middle of a burst. Both clock domains must abandon the partial word, and the next completed word must be dropped again. The stimulus asserts reset about forty cycles into a conversion, restarts, and expects the next word to be dropped and the one after it to be delivered. Requests are also placed both during the conversion pulse and inside the burst, and in the first cycle after a burst ends, so that the boundary between ignored and accepted requests is covered.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT,
    ST_HIGH,
    ST_LOW
  } seq_st_t;

endpackage

// File: rtl/adc_cap_seq.sv
module adc_cap_seq
  import adc_cap_pkg::*;
#(
  parameter int N_BITS   = 16,
  parameter int CYC_CNT  = 64,
  parameter int CNV_HI   = 2,
  parameter int MSB_WAIT = 6,
  parameter int DIV      = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic free_run,
  output logic cnv_o,
  output logic sclk_o
);

  localparam int TW = (CYC_CNT > 2) ? $clog2(CYC_CNT) : 1;
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int PW = (N_BITS > 2) ? $clog2(N_BITS) : 1;
  localparam logic [TW-1:0] T_MAX     = TW'(CYC_CNT - 1);
  localparam logic [TW-1:0] CONV_LAST = TW'(CNV_HI - 1);
  localparam logic [TW-1:0] WAIT_LAST = TW'(MSB_WAIT - 1);
  localparam logic [DW-1:0] D_LAST    = DW'(DIV - 1);
  localparam logic [PW-1:0] P_LAST    = PW'(N_BITS - 1);

  seq_st_t       st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          go;

  assign go = start_req || (free_run && (tmr_q == T_MAX));

  // next-state logic
  always_comb begin
    st_d   = st_q;
    tmr_d  = (tmr_q == T_MAX) ? tmr_q : tmr_q + 1'b1;
    dcnt_d = dcnt_q;
    pcnt_d = pcnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (go) begin
          st_d  = ST_CONV;
          tmr_d = '0;
        end
      end
      ST_CONV: begin
        if (tmr_q == CONV_LAST) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (tmr_q == WAIT_LAST) begin
          st_d   = ST_HIGH;
          dcnt_d = '0;
          pcnt_d = '0;
        end
      end
      ST_HIGH: begin
        if (dcnt_q == D_LAST) begin
          st_d   = ST_LOW;
          dcnt_d = '0;
        end else begin
          dcnt_d = dcnt_q + 1'b1;
        end
      end
      ST_LOW: begin
        if (dcnt_q == D_LAST) begin
          dcnt_d = '0;
          if (pcnt_q == P_LAST) begin
            st_d = ST_IDLE;
          end else begin
            st_d   = ST_HIGH;
            pcnt_d = pcnt_q + 1'b1;
          end
        end else begin
          dcnt_d = dcnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tmr_q  <= T_MAX;
      dcnt_q <= '0;
      pcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      dcnt_q <= dcnt_d;
      pcnt_q <= pcnt_d;
    end
  end

  assign cnv_o  = (st_q == ST_CONV);
  assign sclk_o = (st_q == ST_HIGH);

endmodule

// File: rtl/adc_cap_shift.sv
module adc_cap_shift #(
  parameter int N_BITS = 16
) (
  input  logic              echo_clk,
  input  logic              rst_n,
  input  logic              echo_dat,
  output logic [N_BITS-1:0] word_e,
  output logic              tog_e
);

  localparam int BW = (N_BITS > 2) ? $clog2(N_BITS) : 1;
  localparam logic [BW-1:0] B_LAST = BW'(N_BITS - 1);

  logic [N_BITS-1:0] sr_q, sr_d;
  logic [N_BITS-1:0] wd_q, wd_d;
  logic [BW-1:0]     bc_q, bc_d;
  logic              tg_q, tg_d;
  logic              done;

  assign done = (bc_q == B_LAST);

  always_comb begin
    sr_d = {sr_q[N_BITS-2:0], echo_dat};
    wd_d = wd_q;
    tg_d = tg_q;
    bc_d = bc_q + 1'b1;
    if (done) begin
      wd_d = sr_d;
      tg_d = ~tg_q;
      bc_d = '0;
    end
  end

  always_ff @(posedge echo_clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      wd_q <= '0;
      bc_q <= '0;
      tg_q <= 1'b0;
    end else begin
      sr_q <= sr_d;
      wd_q <= wd_d;
      bc_q <= bc_d;
      tg_q <= tg_d;
    end
  end

  assign word_e = wd_q;
  assign tog_e  = tg_q;

endmodule

// File: rtl/adc_cap_xfer.sv
module adc_cap_xfer #(
  parameter int N_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tog_e,
  input  logic [N_BITS-1:0] word_e,
  output logic [N_BITS-1:0] word_o,
  output logic              word_vld_o
);

  logic [2:0]        sync_q;
  logic              first_q, first_d;
  logic              vld_q, vld_d;
  logic [N_BITS-1:0] word_q, word_d;
  logic              arrive;

  assign arrive = sync_q[1] ^ sync_q[2];

  always_comb begin
    vld_d   = arrive && !first_q;
    first_d = first_q && !arrive;
    word_d  = vld_d ? word_e : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      first_q <= 1'b1;
      vld_q   <= 1'b0;
      word_q  <= '0;
    end else begin
      sync_q  <= {sync_q[1:0], tog_e};
      first_q <= first_d;
      vld_q   <= vld_d;
      word_q  <= word_d;
    end
  end

  assign word_o     = word_q;
  assign word_vld_o = vld_q;

endmodule

// File: rtl/adc_echo_capture.sv
module adc_echo_capture #(
  parameter int N_BITS   = 16,
  parameter int CYC_CNT  = 64,
  parameter int CNV_HI   = 2,
  parameter int MSB_WAIT = 6,
  parameter int DIV      = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              free_run,
  input  logic              echo_clk,
  input  logic              echo_dat,
  output logic              cnv_o,
  output logic              sclk_o,
  output logic [N_BITS-1:0] word_o,
  output logic              word_vld_o,
  output logic              cfg_err_o
);

  localparam int  BURST_END = MSB_WAIT + 2 * N_BITS * DIV;
  localparam bit  CFG_BAD   = (BURST_END >= CYC_CNT) || (MSB_WAIT <= CNV_HI) ||
                              (CNV_HI < 1) || (DIV < 1);

  logic [N_BITS-1:0] word_e;
  logic              tog_e;

  adc_cap_seq #(
    .N_BITS(N_BITS), .CYC_CNT(CYC_CNT), .CNV_HI(CNV_HI),
    .MSB_WAIT(MSB_WAIT), .DIV(DIV)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .free_run(free_run),
    .cnv_o(cnv_o), .sclk_o(sclk_o)
  );

  adc_cap_shift #(.N_BITS(N_BITS)) u_shift (
    .echo_clk(echo_clk), .rst_n(rst_n), .echo_dat(echo_dat),
    .word_e(word_e), .tog_e(tog_e)
  );

  adc_cap_xfer #(.N_BITS(N_BITS)) u_xfer (
    .clk(clk), .rst_n(rst_n), .tog_e(tog_e), .word_e(word_e),
    .word_o(word_o), .word_vld_o(word_vld_o)
  );

  assign cfg_err_o = CFG_BAD;

endmodule

// File: rtl/adc_echo_capture_chk.sv
module adc_echo_capture_chk #(
  parameter int N_BITS   = 16,
  parameter int CNV_HI   = 2,
  parameter int MSB_WAIT = 6,
  parameter int DIV      = 1
) (
  input logic clk,
  input logic rst_n,
  input logic cnv_o,
  input logic sclk_o,
  input logic word_vld_o
);

  localparam int END_T = MSB_WAIT + 2 * N_BITS * DIV;

  int   cnv_len;
  int   since_cnv;
  int   rises;
  logic cnv_d;
  logic sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_len   <= 0;
      since_cnv <= END_T + 1;
      rises     <= 0;
      cnv_d     <= 1'b0;
      sclk_d    <= 1'b0;
    end else begin
      cnv_d   <= cnv_o;
      sclk_d  <= sclk_o;
      cnv_len <= cnv_o ? cnv_len + 1 : 0;
      if (cnv_o && !cnv_d)          since_cnv <= 1;
      else if (since_cnv <= END_T)  since_cnv <= since_cnv + 1;
      if (cnv_o && !cnv_d)          rises <= 0;
      else if (sclk_o && !sclk_d)   rises <= rises + 1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (!cnv_o && !sclk_o && !word_vld_o);
    end
  end

  p_cnv_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_o |-> (cnv_len < CNV_HI));

  p_busy_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> (since_cnv > END_T));

  p_sclk_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> (since_cnv >= MSB_WAIT));

  p_burst_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> (rises < N_BITS));

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnv_o && sclk_o));

  p_vld_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |=> !word_vld_o);

endmodule

bind adc_echo_capture adc_echo_capture_chk #(
  .N_BITS(N_BITS), .CNV_HI(CNV_HI), .MSB_WAIT(MSB_WAIT), .DIV(DIV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnv_o(cnv_o), .sclk_o(sclk_o), .word_vld_o(word_vld_o)
);

// File: tb/test_adc_echo_capture.sv
`timescale 1ns/1ps
module test_adc_echo_capture;

  localparam int NB  = 16;
  localparam int CYC = 100;
  localparam int CH  = 3;
  localparam int MW  = 8;
  localparam int DV  = 2;
  localparam int END_T = MW + 2 * NB * DV;
  localparam int R16_T = MW + 2 * (NB - 1) * DV;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_req = 1'b0;
  logic          free_run = 1'b0;
  logic          echo_clk = 1'b0;
  logic          echo_dat = 1'b0;
  logic          cnv_o, sclk_o, word_vld_o, cfg_err_o;
  logic [NB-1:0] word_o;

  logic          b_cnv, b_sclk, b_vld, b_err;
  logic [NB-1:0] b_word;

  always #2.5 clk = ~clk;

  adc_echo_capture #(
    .N_BITS(NB), .CYC_CNT(CYC), .CNV_HI(CH), .MSB_WAIT(MW), .DIV(DV)
  ) i_adc_echo_capture (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .free_run(free_run),
    .echo_clk(echo_clk), .echo_dat(echo_dat), .cnv_o(cnv_o), .sclk_o(sclk_o),
    .word_o(word_o), .word_vld_o(word_vld_o), .cfg_err_o(cfg_err_o)
  );

  adc_echo_capture #(
    .N_BITS(NB), .CYC_CNT(40), .CNV_HI(CH), .MSB_WAIT(MW), .DIV(DV)
  ) i_adc_echo_capture_bad (
    .clk(clk), .rst_n(rst_n), .start_req(1'b0), .free_run(1'b0),
    .echo_clk(1'b0), .echo_dat(1'b0), .cnv_o(b_cnv), .sclk_o(b_sclk),
    .word_o(b_word), .word_vld_o(b_vld), .cfg_err_o(b_err)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  bit    compare_on = 1'b0;
  string cnv_tag = "R2";

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // converter model: echoed clock and MSB-first data
  always @(sclk_o) echo_clk <= #1 sclk_o;

  logic [NB-1:0] samples [8];
  logic [NB-1:0] adc_sr;
  logic [NB-1:0] exp_q [$];
  int            s_idx = 0;

  initial begin
    samples[0] = 16'hA5C3; samples[1] = 16'h8001;
    samples[2] = 16'hFFFF; samples[3] = 16'h0000;
    samples[4] = 16'h7FFE; samples[5] = 16'h1234;
    samples[6] = 16'hC0DE; samples[7] = 16'h5555;
  end

  always @(posedge cnv_o) begin
    adc_sr = samples[s_idx % 8];
    s_idx++;
    exp_q.push_back(adc_sr);
    echo_dat = adc_sr[NB-1];
  end

  always @(negedge echo_clk) begin
    adc_sr = {adc_sr[NB-2:0], 1'b0};
    echo_dat = adc_sr[NB-1];
  end

  // cycle reference model
  bit            m_busy = 1'b0;
  int            m_t = CYC - 1;
  int            m_cd = 0;
  bit            m_first = 1'b1;
  bit            m_vld = 1'b0;
  bit            m_disc = 1'b0;
  logic [NB-1:0] m_word = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_t = CYC - 1; m_cd = 0; m_first = 1'b1;
      m_vld = 1'b0; m_disc = 1'b0;
      exp_q.delete();
    end else begin
      m_vld = 1'b0;
      m_disc = 1'b0;
      if (m_cd > 0) begin
        m_cd--;
        if (m_cd == 0) begin
          if (m_first) begin
            m_first = 1'b0;
            m_disc = 1'b1;
            if (exp_q.size() > 0) void'(exp_q.pop_front());
          end else begin
            m_vld = 1'b1;
            if (exp_q.size() > 0) m_word = exp_q.pop_front();
          end
        end
      end
      if (m_busy) begin
        m_t++;
        if (m_t == END_T) m_busy = 1'b0;
      end else if (start_req || (free_run && m_t == CYC - 1)) begin
        m_busy = 1'b1;
        m_t = 0;
      end else if (m_t < CYC - 1) begin
        m_t++;
      end
      if (m_busy && m_t == R16_T) m_cd = 3;
    end
  end

  always @(negedge clk) begin
    if (compare_on && rst_n) begin
      bit e_cnv, e_sclk;
      e_cnv  = m_busy && (m_t < CH);
      e_sclk = m_busy && (m_t >= MW) && (m_t < END_T) && (((m_t - MW) / DV) % 2 == 0);
      chk(cnv_o == e_cnv, cnv_tag, "cnv_o", int'(cnv_o), int'(e_cnv));
      chk(sclk_o == e_sclk, "R4", "sclk_o", int'(sclk_o), int'(e_sclk));
      chk(word_vld_o == m_vld, m_disc ? "R8" : "R7", "word_vld_o",
          int'(word_vld_o), int'(m_vld));
      if (m_vld) chk(word_o == m_word, "R6", "word_o", int'(word_o), int'(m_word));
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    cycles(4);
    // R1 reset state, R9 configuration flag
    chk(!cnv_o && !sclk_o && !word_vld_o, "R1", "outputs in reset",
        int'({cnv_o, sclk_o, word_vld_o}), 0);
    chk(cfg_err_o == 1'b0, "R9", "cfg_err_o good setup", int'(cfg_err_o), 0);
    chk(b_err == 1'b1, "R9", "cfg_err_o short cycle", int'(b_err), 1);
    rst_n = 1'b1;
    compare_on = 1'b1;
    cycles(5);

    // R2, R8: first word dropped, then words delivered
    pulse_start(); cycles(110);
    pulse_start(); cycles(110);
    // earliest restart just after a burst ends
    pulse_start(); cycles(END_T);
    pulse_start(); cycles(110);

    // R3: requests during the pulse and inside the burst
    cnv_tag = "R3";
    pulse_start(); cycles(1);
    pulse_start(); cycles(30);
    pulse_start(); cycles(100);
    cnv_tag = "R2";

    // R5: periodic conversions
    cnv_tag = "R5";
    @(negedge clk) free_run = 1'b1;
    cycles(250);
    pulse_start();
    cycles(250);
    @(negedge clk) free_run = 1'b0;
    cycles(120);
    cnv_tag = "R2";

    // R1, R8: reset inside a burst
    pulse_start(); cycles(40);
    @(negedge clk) rst_n = 1'b0;
    cycles(1);
    chk(!cnv_o && !sclk_o && !word_vld_o, "R1", "outputs in mid-burst reset",
        int'({cnv_o, sclk_o, word_vld_o}), 0);
    cycles(2);
    rst_n = 1'b1;
    cycles(3);
    pulse_start(); cycles(110);
    pulse_start(); cycles(110);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule